// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings an embedded display panel up and down in a fixed order, using one timer that counts millisecond ticks. While the power request is held high, the block does the following in order:
- turns on the panel supply;
- waits for hot-plug-detect (HPD) to announce the sink;
- asks for link training and waits for the link-ready acknowledge;
- marks video as valid;
- turns on the backlight supply, then the PWM, then the LED enable.

When the request drops, the same outputs are removed in the opposite order. A minimum off interval then guards the panel supply before any new power-up.

Every wait is a count of tick strobes taken from a configuration input, and a zero count means no wait. For a short window after supply-on, the HPD input is ignored, because the panel may glitch it early in power-up. The HPD-absent limit counts from supply-on and includes that window. It is a timeout when HPD is wired. When HPD is not wired, it is a fixed delay after which the sequence continues as if HPD had asserted.

A timeout powers the panel back down and sets a sticky error. Only a fresh rising edge of the request clears that error and starts a new power-up. A request that drops in the middle of power-up enters power-down at the step that matches the outputs already on.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, every output is low and the block stays idle until the power request rises.
- R2: Power-up drives outputs in this order: panel supply, link training request, video valid, backlight supply, PWM enable, LED enable. Each output stays high only while every output before it is high. Ready is asserted exactly when LED enable is on.
- R3: During the first `t_hpd_rel_i` ticks after the panel supply turns on, a high HPD is ignored, even when HPD later drops before the window ends.
- R4: With HPD wired, if HPD is not high once `t_hpd_abs_i` ticks have passed since supply-on (the ignore window included), the panel supply is turned off and `timeout_o` is set.
- R5: With `no_hpd_i` high, HPD is disregarded, no timeout can occur, and link training is requested once `t_hpd_abs_i` ticks have passed since supply-on.
- R6: The video-to-backlight, backlight-to-PWM and PWM-to-LED gaps each last their programmed number of ticks. A value of zero makes that step advance with no tick at all.
- R7: When the request drops while the panel is on, the outputs are removed one at a time, `t_dn_step_i` ticks apart. The order is: LED enable, PWM, backlight supply, video valid, link training request, and last the panel supply.
- R8: Once the panel supply is off, it stays off for `t_off_min_i` ticks. A request raised during that interval is held and starts power-up when the interval ends.
- R9: A request drop during power-up enters power-down at the step for the highest output currently on, and never turns an output on.
- R10: `timeout_o` is sticky. A timeout does not restart power-up on its own, even while the request stays high. A new rising edge of the request clears the error and starts a new power-up.
- R11: `busy_o` is high in every state except fully off and fully on, and never together with `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| tick_i | input | 1 | One-cycle millisecond timebase strobe |
| pwr_req_i | input | 1 | Level power request; high means panel wanted on |
| hpd_i | input | 1 | Hot-plug-detect from the panel (asynchronous) |
| link_ok_i | input | 1 | Link training finished acknowledge |
| no_hpd_i | input | 1 | Static mode: HPD not wired |
| t_hpd_rel_i | input | DLY_W | Ticks during which HPD is ignored after supply-on |
| t_hpd_abs_i | input | DLY_W | Ticks from supply-on until HPD timeout or fixed wait end |
| t_vid_bl_i | input | DLY_W | Ticks from video valid to backlight supply |
| t_bl_pwm_i | input | DLY_W | Ticks from backlight supply to PWM enable |
| t_pwm_led_i | input | DLY_W | Ticks from PWM enable to LED enable |
| t_dn_step_i | input | DLY_W | Ticks between power-down steps |
| t_off_min_i | input | DLY_W | Minimum supply-off ticks before a new power-up |
| panel_pwr_o | output | 1 | Panel supply enable |
| link_train_o | output | 1 | Link training request / link active |
| video_on_o | output | 1 | Valid video (low means black) |
| bl_pwr_o | output | 1 | Backlight supply enable |
| pwm_en_o | output | 1 | PWM enable |
| led_en_o | output | 1 | LED enable |
| ready_o | output | 1 | Panel fully on |
| busy_o | output | 1 | Sequence in progress |
| timeout_o | output | 1 | Sticky HPD timeout error |

## Verification
The first power-up has an HPD pulse that appears and vanishes inside the ignore window. This shows that the wait really ends on HPD seen after the window, not on any earlier edge. A second run keeps HPD low and counts ticks up to one short of the absent limit and then up to the limit. This separates a limit measured from supply-on, which includes the window, from one measured from the end of the window. A drop of the request with the backlight on, but before the PWM, shows that power-down enters at the matching step. A run with HPD not wired and all gap delays set to zero shows the fixed wait and the zero-count steps that advance with no tick.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [3:0] {
        ST_OFF, ST_SUP_ON, ST_HPD_WAIT, ST_TRAIN, ST_VID_GAP, ST_BL_ON,
        ST_PWM_ON, ST_ON, ST_DN_LED, ST_DN_PWM, ST_DN_BL, ST_DN_VID,
        ST_DN_LINK, ST_DN_SUP
    } pps_state_e;

    typedef struct packed {
        logic sup;
        logic train;
        logic vid;
        logic bl;
        logic pwm;
        logic led;
    } pps_rails_t;

    typedef struct packed {
        pps_state_e st;
        pps_rails_t rails;
        logic       err;
        logic       want;
        logic       req_prev;
        logic       ready;
        logic       busy;
    } pps_regs_t;

    // outputs that are on in each state
    function automatic pps_rails_t rails_of(pps_state_e s);
        pps_rails_t r;
        r = '0;
        unique case (s)
            ST_OFF, ST_DN_SUP:                 r = '0;
            ST_SUP_ON, ST_HPD_WAIT, ST_DN_LINK: r = 6'b100000;
            ST_TRAIN, ST_DN_VID:               r = 6'b110000;
            ST_VID_GAP, ST_DN_BL:              r = 6'b111000;
            ST_BL_ON, ST_DN_PWM:               r = 6'b111100;
            ST_PWM_ON, ST_DN_LED:              r = 6'b111110;
            ST_ON:                             r = 6'b111111;
            default:                           r = '0;
        endcase
        return r;
    endfunction

    // power-down entry that removes the highest output currently on
    function automatic pps_state_e down_entry(pps_rails_t r);
        if (r.led)        return ST_DN_LED;
        else if (r.pwm)   return ST_DN_PWM;
        else if (r.bl)    return ST_DN_BL;
        else if (r.vid)   return ST_DN_VID;
        else if (r.train) return ST_DN_LINK;
        else if (r.sup)   return ST_DN_SUP;
        else              return ST_OFF;
    endfunction

endpackage

// File: rtl/pps_tick_timer.sv
module pps_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (tick_i && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q >= limit_i);
endmodule

// File: rtl/pps_hpd_sync.sv
module pps_hpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hpd_i,
    output logic hpd_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_one
            assign sync_d = hpd_i;
        end else begin : g_many
            assign sync_d = {sync_q[STAGES-2:0], hpd_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign hpd_o = sync_q[STAGES-1];
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int DLY_W      = 16,
    parameter int HPD_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             pwr_req_i,
    input  logic             hpd_i,
    input  logic             link_ok_i,
    input  logic             no_hpd_i,
    input  logic [DLY_W-1:0] t_hpd_rel_i,
    input  logic [DLY_W-1:0] t_hpd_abs_i,
    input  logic [DLY_W-1:0] t_vid_bl_i,
    input  logic [DLY_W-1:0] t_bl_pwm_i,
    input  logic [DLY_W-1:0] t_pwm_led_i,
    input  logic [DLY_W-1:0] t_dn_step_i,
    input  logic [DLY_W-1:0] t_off_min_i,
    output logic             panel_pwr_o,
    output logic             link_train_o,
    output logic             video_on_o,
    output logic             bl_pwr_o,
    output logic             pwm_en_o,
    output logic             led_en_o,
    output logic             ready_o,
    output logic             busy_o,
    output logic             timeout_o
);
    pps_regs_t        r_d, r_q;
    logic [DLY_W-1:0] step_lim;
    logic             step_done, abs_done, abs_clear, step_clear, hpd_q;
    logic             req_rise, timeout;
    pps_state_e       nxt;

    pps_hpd_sync #(.STAGES(HPD_STAGES)) u_hpd (
        .clk_i (clk_i), .rst_ni(rst_ni), .hpd_i(hpd_i), .hpd_o(hpd_q)
    );

    // per-step limit
    always_comb begin
        unique case (r_q.st)
            ST_SUP_ON:  step_lim = t_hpd_rel_i;
            ST_VID_GAP: step_lim = t_vid_bl_i;
            ST_BL_ON:   step_lim = t_bl_pwm_i;
            ST_PWM_ON:  step_lim = t_pwm_led_i;
            ST_DN_LED, ST_DN_PWM, ST_DN_BL, ST_DN_VID, ST_DN_LINK:
                        step_lim = t_dn_step_i;
            ST_DN_SUP:  step_lim = t_off_min_i;
            default:    step_lim = '0;
        endcase
    end

    assign step_clear = (nxt != r_q.st);
    assign abs_clear  = !(r_q.st == ST_SUP_ON || r_q.st == ST_HPD_WAIT);

    pps_tick_timer #(.W(DLY_W)) u_step_tmr (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(step_clear), .tick_i(tick_i),
        .limit_i(step_lim), .done_o(step_done)
    );

    // counts from supply-on, reliable window included
    pps_tick_timer #(.W(DLY_W)) u_abs_tmr (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(abs_clear), .tick_i(tick_i),
        .limit_i(t_hpd_abs_i), .done_o(abs_done)
    );

    assign req_rise = pwr_req_i && !r_q.req_prev;

    // next-state logic
    always_comb begin
        nxt     = r_q.st;
        timeout = 1'b0;
        unique case (r_q.st)
            ST_OFF:
                if (r_q.want) nxt = ST_SUP_ON;
            ST_SUP_ON:
                if (!r_q.want)     nxt = down_entry(r_q.rails);
                else if (step_done) nxt = ST_HPD_WAIT;
            ST_HPD_WAIT:
                if (!r_q.want) nxt = down_entry(r_q.rails);
                else if (no_hpd_i) begin
                    if (abs_done) nxt = ST_TRAIN;
                end else if (hpd_q) nxt = ST_TRAIN;
                else if (abs_done) begin
                    timeout = 1'b1;
                    nxt     = down_entry(r_q.rails);
                end
            ST_TRAIN:
                if (!r_q.want)      nxt = down_entry(r_q.rails);
                else if (link_ok_i) nxt = ST_VID_GAP;
            ST_VID_GAP:
                if (!r_q.want)      nxt = down_entry(r_q.rails);
                else if (step_done) nxt = ST_BL_ON;
            ST_BL_ON:
                if (!r_q.want)      nxt = down_entry(r_q.rails);
                else if (step_done) nxt = ST_PWM_ON;
            ST_PWM_ON:
                if (!r_q.want)      nxt = down_entry(r_q.rails);
                else if (step_done) nxt = ST_ON;
            ST_ON:
                if (!r_q.want) nxt = ST_DN_LED;
            ST_DN_LED:  if (step_done) nxt = ST_DN_PWM;
            ST_DN_PWM:  if (step_done) nxt = ST_DN_BL;
            ST_DN_BL:   if (step_done) nxt = ST_DN_VID;
            ST_DN_VID:  if (step_done) nxt = ST_DN_LINK;
            ST_DN_LINK: if (step_done) nxt = ST_DN_SUP;
            ST_DN_SUP:  if (step_done) nxt = ST_OFF;
            default:    nxt = ST_OFF;
        endcase
    end

    // register next values
    always_comb begin
        r_d          = r_q;
        r_d.req_prev = pwr_req_i;
        if (req_rise) begin
            r_d.want = 1'b1;
            r_d.err  = 1'b0;
        end
        if (!pwr_req_i) r_d.want = 1'b0;
        if (timeout) begin
            r_d.err  = 1'b1;
            r_d.want = 1'b0;
        end
        r_d.st    = nxt;
        r_d.rails = rails_of(nxt);
        r_d.ready = (nxt == ST_ON);
        r_d.busy  = (nxt != ST_ON) && (nxt != ST_OFF);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= ST_OFF;
        end else begin
            r_q <= r_d;
        end
    end

    assign panel_pwr_o  = r_q.rails.sup;
    assign link_train_o = r_q.rails.train;
    assign video_on_o   = r_q.rails.vid;
    assign bl_pwr_o     = r_q.rails.bl;
    assign pwm_en_o     = r_q.rails.pwm;
    assign led_en_o     = r_q.rails.led;
    assign ready_o      = r_q.ready;
    assign busy_o       = r_q.busy;
    assign timeout_o    = r_q.err;
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic pwr_req_i,
    input logic no_hpd_i,
    input logic panel_pwr_o,
    input logic link_train_o,
    input logic video_on_o,
    input logic bl_pwr_o,
    input logic pwm_en_o,
    input logic led_en_o,
    input logic ready_o,
    input logic busy_o,
    input logic timeout_o
);
    assert_led_needs_pwm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        led_en_o |-> pwm_en_o);
    assert_pwm_needs_bl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwm_en_o |-> bl_pwr_o);
    assert_bl_needs_vid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bl_pwr_o |-> video_on_o);
    assert_vid_needs_link_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        video_on_o |-> link_train_o);
    assert_link_needs_sup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_train_o |-> panel_pwr_o);
    assert_ready_means_led_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> led_en_o);
    assert_timeout_drops_sup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> (!panel_pwr_o && busy_o));
    assert_no_timeout_nohpd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        no_hpd_i |-> !$rose(timeout_o));
    assert_sup_from_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(panel_pwr_o) |-> $past(!busy_o && !ready_o));
    assert_err_clear_on_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(timeout_o) |-> pwr_req_i);
    assert_busy_ready_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && ready_o));
endmodule

bind panel_pwr_seq pps_checker u_pps_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_req_i(pwr_req_i), .no_hpd_i(no_hpd_i),
    .panel_pwr_o(panel_pwr_o), .link_train_o(link_train_o), .video_on_o(video_on_o),
    .bl_pwr_o(bl_pwr_o), .pwm_en_o(pwm_en_o), .led_en_o(led_en_o),
    .ready_o(ready_o), .busy_o(busy_o), .timeout_o(timeout_o)
);

// File: tb/panel_pwr_seq_bench.sv
module panel_pwr_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, req = 1'b0;
    logic hpd = 1'b0, link_ok = 1'b0, no_hpd = 1'b0;
    logic [DW-1:0] t_rel = 3, t_abs = 10, t_vb = 2, t_bp = 2, t_pl = 1, t_dn = 1, t_off = 4;
    logic sup, train, vid, bl, pwm, led, ready, busy, err;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    string      tag_q[$];
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_pwr_seq #(.DLY_W(DW)) u_panel_pwr_seq (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pwr_req_i(req), .hpd_i(hpd),
        .link_ok_i(link_ok), .no_hpd_i(no_hpd), .t_hpd_rel_i(t_rel), .t_hpd_abs_i(t_abs),
        .t_vid_bl_i(t_vb), .t_bl_pwm_i(t_bp), .t_pwm_led_i(t_pl), .t_dn_step_i(t_dn),
        .t_off_min_i(t_off), .panel_pwr_o(sup), .link_train_o(train), .video_on_o(vid),
        .bl_pwr_o(bl), .pwm_en_o(pwm), .led_en_o(led), .ready_o(ready), .busy_o(busy),
        .timeout_o(err)
    );

    // monitor: compares queued expectations at the next falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                string tg;
                logic [8:0] ex, act;
                tg  = tag_q.pop_front();
                ex  = exp_q.pop_front();
                act = {err, busy, ready, led, pwm, bl, vid, train, sup};
                n_tests++;
                if (act !== ex) begin
                    n_fail++;
                    $display("FAIL %s: {err,busy,ready,led,pwm,bl,vid,train,sup} got %b expected %b",
                             tg, act, ex);
                end
            end
        end
    end

    // driver side: push expectation, let monitor sample it
    task automatic expect_out(input string tg, input logic [8:0] ex);
        tag_q.push_back(tg);
        exp_q.push_back(ex);
        @(negedge clk);
        #1;
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            clocks(2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clocks(3);
        expect_out("R1 reset", 9'b000000000);
        rst_n = 1'b1;
        clocks(5);
        expect_out("R1 idle without request", 9'b000000000);

        // normal power-up with an early HPD glitch
        req = 1'b1; clocks(4);
        expect_out("R2 supply first", 9'b010000001);
        hpd = 1'b1; ticks(1); hpd = 1'b0; clocks(4); ticks(2); clocks(4);
        expect_out("R3 glitch in window ignored", 9'b010000001);
        hpd = 1'b1; clocks(5);
        expect_out("R2 train after hpd", 9'b010000011);
        link_ok = 1'b1; clocks(3);
        expect_out("R2 video valid", 9'b010000111);
        ticks(1);
        expect_out("R6 gap not yet over", 9'b010000111);
        ticks(1);
        expect_out("R6 backlight supply", 9'b010001111);
        ticks(2);
        expect_out("R2 pwm", 9'b010011111);
        ticks(1); clocks(2);
        expect_out("R2 led and ready", 9'b001111111);

        // full power-down
        req = 1'b0; clocks(3);
        expect_out("R7 led off", 9'b010011111);
        ticks(1);
        expect_out("R7 pwm off", 9'b010001111);
        ticks(1);
        expect_out("R7 backlight off", 9'b010000111);
        ticks(1);
        expect_out("R7 video black", 9'b010000011);
        ticks(1);
        expect_out("R7 link off", 9'b010000001);
        ticks(1);
        expect_out("R7 supply off", 9'b010000000);

        // request during minimum off time
        req = 1'b1; hpd = 1'b0; clocks(2); ticks(3);
        expect_out("R8 request held", 9'b010000000);
        ticks(1); clocks(3);
        expect_out("R8 power-up after off time", 9'b010000001);

        // timeout: 3 window + 7 more ticks
        ticks(9);
        expect_out("R4 no timeout before limit", 9'b010000001);
        ticks(1);
        expect_out("R4 timeout at limit", 9'b110000000);
        ticks(4); clocks(4);
        expect_out("R10 no restart after timeout", 9'b100000000);
        req = 1'b0; clocks(3); req = 1'b1; clocks(4);
        expect_out("R10 new request clears error", 9'b010000001);

        // abort with backlight on
        hpd = 1'b1; ticks(3); clocks(4); ticks(2);
        expect_out("R9 reached backlight", 9'b010001111);
        req = 1'b0; clocks(3);
        expect_out("R9 abort enters at backlight", 9'b010000111);
        ticks(2);
        expect_out("R9 down continues", 9'b010000001);
        ticks(5);
        expect_out("R9 fully off", 9'b000000000);

        // HPD not wired, zero gaps
        no_hpd = 1'b1; hpd = 1'b0; t_vb = 0; t_bp = 0; t_pl = 0;
        req = 1'b1; clocks(4); ticks(9);
        expect_out("R5 fixed wait not over", 9'b010000001);
        ticks(1); clocks(8);
        expect_out("R5 R6 on with zero gaps", 9'b001111111);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule